// File: doc/BRIEF.md
# PCI Host Access Translator

This block sits between a local bus master and a simple PCI host bridge. It turns one local read or write at a time into address phases on the PCI side. The mode is set by a small misc control register. In memory mode, a request aimed at a fixed 1 GiB local window becomes a bus memory cycle. The two top bus address bits come from the control register. In configuration mode, the device, function and register fields of the request become a type-0 configuration address, in which the device number selects a single IDSEL line.

Byte and halfword accesses are handled inside the block. Reads pull the addressed lanes out of the returned dword. Writes are carried out as a read, a merge and a write-back, so the bytes that were not addressed keep their old values. A target abort gives the local side an error response and sets a sticky abort flag. The same control register also sets the direction and level of the PCI reset pin.

Top module: `pci_host_xlat`

## Requirements
- R1: In memory mode (control bit 1 clear), a request with req_addr[31:30] = 2'b10 produces a bus cycle with command 4'h6 for a read or 4'h7 for a write. bus_addr[29:2] equals req_addr[29:2] and bus_addr[1:0] is zero. Any other request address gives an error response with data 0xFFFFFFFF and no bus cycle.
- R2: In memory mode, bus_addr[31:30] equals control register bits [3:2], as they stand when the request is accepted.
- R3: With control bit 1 set, the request fields are read as follows: device = req_addr[15:11], function = req_addr[10:8], register = req_addr[7:0]. The bus address is (1 << (13 + device)) | (function << 8) | (register with bits 1:0 cleared). The command is 4'hA for a read and 4'hB for a write.
- R4: A configuration request whose device number is above 18, or whose formed address is 0x00100000 or more (so any device of 7 or above), gets an error response with data 0xFFFFFFFF. It issues no bus cycle and leaves the abort flag unchanged.
- R5: req_size selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. Read data is the dword shifted right by 8 × req_addr[1:0], then masked to that width.
- R6: A sub-word memory write, and every configuration write, reads the dword first. It then writes the dword back with only the addressed bytes replaced. A full-word memory write issues a single write cycle. A successful write responds with data 0 and no error.
- R7: If the target aborts a read cycle, the response is data 0xFFFFFFFF with the error flag set, and abort_flag is set. When that read is the first phase of a read-merge-write, no write cycle follows.
- R8: If the target aborts a write cycle, the response has the error flag set and data 0xFFFFFFFF, and abort_flag is set.
- R9: abort_flag stays set until abort_clr is asserted with no abort arriving in the same cycle.
- R10: Control bits [5:4] set the reset pin: 0 leaves it an input (rst_pin_oe = 0), 1 drives it low, 2 drives it high, and 3 leaves it an input.
- R11: Only one transaction is in flight at a time. req_ready is low from acceptance until the response has been taken. A response stays valid, with stable data, until rsp_ready. bus_req, bus_cmd and bus_addr stay stable until bus_ack.
- R12: After reset, the control register reads 0 (memory mode, reset pin an input), req_ready is 1, and rsp_valid, bus_req and abort_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| misc_we | input | 1 | Control register write strobe |
| misc_wdata | input | 8 | Control register write value |
| misc_q | output | 8 | Control register contents (implemented bits 5:1) |
| abort_clr | input | 1 | Clears the sticky abort flag |
| abort_flag | output | 1 | Sticky bus abort status |
| rst_pin_oe | output | 1 | Reset pin output enable |
| rst_pin_o | output | 1 | Reset pin driven level |
| req_valid | input | 1 | Local request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code |
| req_addr | input | 32 | Local address or configuration selection |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Response data |
| rsp_err | output | 1 | Response error (rejected or aborted) |
| bus_req | output | 1 | Bus cycle request, held until acknowledged |
| bus_cmd | output | 4 | Bus command code |
| bus_addr | output | 32 | Bus address phase value |
| bus_wdata | output | 32 | Bus write dword |
| bus_ack | input | 1 | One-cycle bus completion |
| bus_abort | input | 1 | Completion was an abort (valid with bus_ack) |
| bus_rdata | input | 32 | Bus read dword (valid with bus_ack) |

## Verification
The bench issues byte and halfword reads at every lane offset, including a halfword at offset 3 that must keep only the top byte. A design that shifts or masks wrongly returns bytes from the wrong lanes. It runs sub-word writes in both modes and reads them back. A design that writes without a merge would wipe out the neighbouring bytes. The bench also aborts the read phase of a merge. A design that does not stop at that point would still put out a write cycle, and the target model flags that as an unexpected bus cycle. Configuration requests for devices 0, 2, 7 and 19 cover the IDSEL bit placement, the limit on the formed address (device 7 lands exactly on it) and the device range check. A design with an off-by-one limit would issue a bus cycle there. Finally, the bench holds responses back to check that a second request cannot enter, and walks all four reset pin modes.

// File: rtl/hostbr_pkg.sv
package hostbr_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  localparam logic [3:0] CMD_MEM_RD = 4'h6;
  localparam logic [3:0] CMD_MEM_WR = 4'h7;
  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_GAP,
    ST_WR,
    ST_RSP
  } seq_state_e;

  typedef struct packed {
    logic              ok;
    logic              is_cfg;
    logic [1:0]        off;
    logic [ADDR_W-1:0] addr;
  } xlat_t;
endpackage

// File: rtl/hostbr_misc_reg.sv
module hostbr_misc_reg #(
  parameter int MISC_W  = 8,
  parameter int MODE_LSB = 4,
  parameter logic [MISC_W-1:0] KEEP_MASK = 8'h3E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [MISC_W-1:0] wdata,
  output logic [MISC_W-1:0] q,
  output logic              pin_oe,
  output logic              pin_o
);
  logic [1:0] mode_new;
  assign mode_new = wdata[MODE_LSB +: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      pin_oe <= 1'b0;
      pin_o  <= 1'b0;
    end else if (we) begin
      q <= wdata & KEEP_MASK;
      case (mode_new)
        2'b01:   begin pin_oe <= 1'b1; pin_o <= 1'b0; end
        2'b10:   begin pin_oe <= 1'b1; pin_o <= 1'b1; end
        default: begin pin_oe <= 1'b0; pin_o <= 1'b0; end
      endcase
    end
  end

  assert_pin_input_R10: assert property (@(posedge clk) disable iff (rst)
    (q[MODE_LSB +: 2] == 2'b00 || q[MODE_LSB +: 2] == 2'b11) |-> !pin_oe);
  assert_pin_low_R10: assert property (@(posedge clk) disable iff (rst)
    (q[MODE_LSB +: 2] == 2'b01) |-> (pin_oe && !pin_o));
  assert_pin_high_R10: assert property (@(posedge clk) disable iff (rst)
    (q[MODE_LSB +: 2] == 2'b10) |-> (pin_oe && pin_o));
endmodule

// File: rtl/hostbr_decode.sv
module hostbr_decode
  import hostbr_pkg::*;
#(
  parameter int DEV_W      = 5,
  parameter int FN_W       = 3,
  parameter int REG_W      = 8,
  parameter int MAX_DEV    = 18,
  parameter int IDSEL_BASE = 13,
  parameter logic [ADDR_W-1:0] CFG_LIMIT = 32'h0010_0000
) (
  input  logic              cfg_sel,
  input  logic [1:0]        hi_bits,
  input  logic [ADDR_W-1:0] req_addr,
  output xlat_t             xl
);
  localparam int FN_LSB  = REG_W;
  localparam int DEV_LSB = REG_W + FN_W;

  logic [DEV_W-1:0]  dev;
  logic [FN_W-1:0]   fn;
  logic [REG_W-1:0]  rg;
  logic [ADDR_W-1:0] idsel;
  logic [ADDR_W-1:0] cfg_addr;
  logic              dev_ok;
  logic              win_ok;

  assign dev = req_addr[DEV_LSB +: DEV_W];
  assign fn  = req_addr[FN_LSB +: FN_W];
  assign rg  = req_addr[REG_W-1:0];

  always_comb begin
    dev_ok   = (int'(dev) <= MAX_DEV);
    idsel    = dev_ok ? (ADDR_W'(1) << (IDSEL_BASE + int'(dev))) : '0;
    cfg_addr = idsel | (ADDR_W'(fn) << FN_LSB) | ADDR_W'({rg[REG_W-1:2], 2'b00});
    win_ok   = (req_addr[ADDR_W-1 -: 2] == 2'b10);
    xl.off   = req_addr[1:0];
    if (cfg_sel) begin
      xl.is_cfg = 1'b1;
      xl.ok     = dev_ok && (cfg_addr < CFG_LIMIT);
      xl.addr   = cfg_addr;
    end else begin
      xl.is_cfg = 1'b0;
      xl.ok     = win_ok;
      xl.addr   = {hi_bits, req_addr[ADDR_W-3:2], 2'b00};
    end
  end
endmodule

// File: rtl/hostbr_lanes.sv
module hostbr_lanes
  import hostbr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [1:0]    size,
  input  logic [1:0]    off,
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] new_data,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] merged
);
  localparam int NB  = DW / 8;
  localparam int SHW = $clog2(DW);

  logic [DW-1:0]  size_mask;
  logic [DW-1:0]  shifted;
  logic [SHW-1:0] sh;
  int             nbytes;
  logic [NB-1:0]  lane_on;

  always_comb begin
    case (size)
      2'd0:    begin size_mask = DW'(8'hFF);    nbytes = 1;  end
      2'd1:    begin size_mask = DW'(16'hFFFF); nbytes = 2;  end
      default: begin size_mask = '1;            nbytes = NB; end
    endcase
    sh      = SHW'(off) << 3;
    rd_data = (old_word >> sh) & size_mask;
    shifted = (new_data & size_mask) << sh;
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_on[g] = (g >= int'(off)) && (g < int'(off) + nbytes);
    assign merged[8*g +: 8] = lane_on[g] ? shifted[8*g +: 8] : old_word[8*g +: 8];
  end
endmodule

// File: rtl/pci_host_xlat.sv
module pci_host_xlat
  import hostbr_pkg::*;
#(
  parameter int DEV_W      = 5,
  parameter int FN_W       = 3,
  parameter int REG_W      = 8,
  parameter int MAX_DEV    = 18,
  parameter int IDSEL_BASE = 13,
  parameter logic [ADDR_W-1:0] CFG_LIMIT = 32'h0010_0000,
  parameter int MISC_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              misc_we,
  input  logic [MISC_W-1:0] misc_wdata,
  output logic [MISC_W-1:0] misc_q,
  input  logic              abort_clr,
  output logic              abort_flag,
  output logic              rst_pin_oe,
  output logic              rst_pin_o,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              bus_req,
  output logic [3:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_abort,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int IDSEL_LSB = REG_W + FN_W;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  seq_state_e        state;
  xlat_t             xl;
  logic              lat_cfg;
  logic              lat_write;
  logic [1:0]        lat_size;
  logic [1:0]        lat_off;
  logic [DATA_W-1:0] lat_wdata;
  logic [DATA_W-1:0] rd_ext;
  logic [DATA_W-1:0] merged;
  logic              full_word;

  hostbr_misc_reg #(.MISC_W(MISC_W)) u_misc (
    .clk    (clk),
    .rst    (rst),
    .we     (misc_we),
    .wdata  (misc_wdata),
    .q      (misc_q),
    .pin_oe (rst_pin_oe),
    .pin_o  (rst_pin_o)
  );

  hostbr_decode #(
    .DEV_W(DEV_W), .FN_W(FN_W), .REG_W(REG_W), .MAX_DEV(MAX_DEV),
    .IDSEL_BASE(IDSEL_BASE), .CFG_LIMIT(CFG_LIMIT)
  ) u_dec (
    .cfg_sel  (misc_q[1]),
    .hi_bits  (misc_q[3:2]),
    .req_addr (req_addr),
    .xl       (xl)
  );

  hostbr_lanes #(.DW(DATA_W)) u_lanes (
    .size     (lat_size),
    .off      (lat_off),
    .old_word (bus_rdata),
    .new_data (lat_wdata),
    .rd_data  (rd_ext),
    .merged   (merged)
  );

  assign req_ready = (state == ST_IDLE);
  assign full_word = req_size[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_req   <= 1'b0;
      bus_cmd   <= CMD_MEM_RD;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      lat_cfg   <= 1'b0;
      lat_write <= 1'b0;
      lat_size  <= 2'd0;
      lat_off   <= 2'd0;
      lat_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            lat_cfg   <= xl.is_cfg;
            lat_write <= req_write;
            lat_size  <= req_size;
            lat_off   <= xl.off;
            lat_wdata <= req_wdata;
            if (!xl.ok) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= ALL_ONES;
              state     <= ST_RSP;
            end else begin
              bus_addr <= xl.addr;
              bus_req  <= 1'b1;
              if (req_write && !xl.is_cfg && full_word) begin
                bus_cmd   <= CMD_MEM_WR;
                bus_wdata <= req_wdata;
                state     <= ST_WR;
              end else begin
                bus_cmd <= xl.is_cfg ? CMD_CFG_RD : CMD_MEM_RD;
                state   <= ST_RD;
              end
            end
          end
        end
        ST_RD: begin
          if (bus_ack) begin
            bus_req <= 1'b0;
            if (bus_abort) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= ALL_ONES;
              state     <= ST_RSP;
            end else if (lat_write) begin
              bus_wdata <= merged;
              bus_cmd   <= lat_cfg ? CMD_CFG_WR : CMD_MEM_WR;
              state     <= ST_GAP;
            end else begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b0;
              rsp_rdata <= rd_ext;
              state     <= ST_RSP;
            end
          end
        end
        ST_GAP: begin
          bus_req <= 1'b1;
          state   <= ST_WR;
        end
        ST_WR: begin
          if (bus_ack) begin
            bus_req   <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= bus_abort;
            rsp_rdata <= bus_abort ? ALL_ONES : '0;
            state     <= ST_RSP;
          end
        end
        ST_RSP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                abort_flag <= 1'b0;
    else if (bus_req && bus_ack && bus_abort) abort_flag <= 1'b1;
    else if (abort_clr)                     abort_flag <= 1'b0;
  end

  assert_bus_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_cmd)));
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
  assert_single_txn_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || bus_req) |-> !req_ready);
  assert_word_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_addr[1:0] == 2'b00));
  assert_idsel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && (bus_cmd == CMD_CFG_RD || bus_cmd == CMD_CFG_WR))
      |-> ($countones(bus_addr[ADDR_W-1:IDSEL_LSB]) == 1));
  assert_reject_no_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && req_valid && !xl.ok) |=> !bus_req);
  assert_abort_latch_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack && bus_abort) |=> abort_flag);
endmodule

// File: tb/pci_host_xlat_tb_top.sv
module pci_host_xlat_tb_top;
  import hostbr_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        misc_we = 1'b0;
  logic [7:0]  misc_wdata = '0;
  logic [7:0]  misc_q;
  logic        abort_clr = 1'b0;
  logic        abort_flag, rst_pin_oe, rst_pin_o;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_err;
  logic [31:0] rsp_rdata;
  logic        bus_req;
  logic [3:0]  bus_cmd;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_ack = 1'b0, bus_abort = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #10 clk = ~clk;

  pci_host_xlat dut_i (
    .clk(clk), .rst(rst), .misc_we(misc_we), .misc_wdata(misc_wdata), .misc_q(misc_q),
    .abort_clr(abort_clr), .abort_flag(abort_flag), .rst_pin_oe(rst_pin_oe), .rst_pin_o(rst_pin_o),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .bus_req(bus_req), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_abort(bus_abort),
    .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } bus_item_t;
  typedef struct {
    logic [31:0] d;
    logic        e;
    string       tag;
  } rsp_item_t;

  bus_item_t exp_bus[$];
  rsp_item_t exp_rsp[$];

  logic [31:0] mem_arr [16];
  logic [31:0] cfg_arr [16];
  logic        tb_cfg = 1'b0;
  logic [1:0]  tb_hi = 2'b00;
  logic        tb_abort = 1'b0;
  logic        hold_rsp = 1'b0;
  int          bus_cnt = 0;
  int          lat_cnt = 0;
  int          stall_cnt = 0;

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem_arr[i] = 32'h1122_3344 + i * 32'h0102_0304;
      cfg_arr[i] = 32'hA5C3_0F96 ^ (i * 32'h1111_1111);
    end
  end

  // Behavioural target: acks after two cycles, aborts per address rule.
  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0;
      bus_abort <= 1'b0;
      lat_cnt <= 0;
    end else if (bus_ack) begin
      bus_ack <= 1'b0;
    end else if (bus_req) begin
      if (lat_cnt == 1) begin
        bit is_cfg, is_wr, ab;
        bus_item_t it;
        lat_cnt <= 0;
        bus_cnt++;
        is_cfg = (bus_cmd == CMD_CFG_RD || bus_cmd == CMD_CFG_WR);
        is_wr  = (bus_cmd == CMD_MEM_WR || bus_cmd == CMD_CFG_WR);
        ab = is_cfg ? !bus_addr[15] : (bus_addr[27:20] == 8'hFF);
        if (exp_bus.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R4/R7 unexpected bus cycle actual=%h expected=none", bus_addr);
        end else begin
          it = exp_bus.pop_front();
          chk({it.tag, " bus_cmd"}, {28'd0, bus_cmd}, {28'd0, it.cmd});
          chk({it.tag, " bus_addr"}, bus_addr, it.addr);
          if (is_wr) chk({it.tag, " bus_wdata"}, bus_wdata, it.data);
        end
        bus_rdata <= is_cfg ? cfg_arr[bus_addr[5:2]] : mem_arr[bus_addr[5:2]];
        if (is_wr && !ab) begin
          if (is_cfg) cfg_arr[bus_addr[5:2]] = bus_wdata;
          else        mem_arr[bus_addr[5:2]] = bus_wdata;
        end
        bus_abort <= ab;
        bus_ack <= 1'b1;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 1;
    rsp_ready <= hold_rsp ? 1'b0 : ((stall_cnt % 3) != 0);
  end

  // Monitor: compares each consumed response with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && rsp_valid && rsp_ready) begin
      if (exp_rsp.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        rsp_item_t r;
        r = exp_rsp.pop_front();
        chk({r.tag, " rsp_rdata"}, rsp_rdata, r.d);
        chk({r.tag, " rsp_err"}, {31'd0, rsp_err}, {31'd0, r.e});
      end
    end
  end

  task automatic issue(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd, input string tag);
    logic [4:0]  dev = a[15:11];
    logic [2:0]  fn  = a[10:8];
    logic [7:0]  rg  = a[7:0];
    logic [31:0] ba, old, mask, mrg;
    int          sh = int'(a[1:0]) * 8;
    bit          ok, ab;
    logic [3:0]  rcmd = tb_cfg ? CMD_CFG_RD : CMD_MEM_RD;
    logic [3:0]  wcmd = tb_cfg ? CMD_CFG_WR : CMD_MEM_WR;
    if (tb_cfg) begin
      if (dev > 18) begin ok = 0; ba = '0; end
      else begin
        ba = (32'h1 << (13 + int'(dev))) | (32'(fn) << 8) | {24'd0, rg[7:2], 2'b00};
        ok = (ba < 32'h0010_0000);
      end
    end else begin
      ok = (a[31:30] == 2'b10);
      ba = {tb_hi, a[29:2], 2'b00};
    end
    mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    if (!ok) begin
      exp_rsp.push_back('{32'hFFFF_FFFF, 1'b1, tag});
    end else begin
      ab  = tb_cfg ? !ba[15] : (ba[27:20] == 8'hFF);
      old = tb_cfg ? cfg_arr[ba[5:2]] : mem_arr[ba[5:2]];
      if (ab) tb_abort = 1'b1;
      if (!wr) begin
        exp_bus.push_back('{rcmd, ba, 32'd0, tag});
        if (ab) exp_rsp.push_back('{32'hFFFF_FFFF, 1'b1, tag});
        else    exp_rsp.push_back('{(old >> sh) & mask, 1'b0, tag});
      end else if (!tb_cfg && sz[1]) begin
        exp_bus.push_back('{wcmd, ba, wd, tag});
        if (ab) exp_rsp.push_back('{32'hFFFF_FFFF, 1'b1, tag});
        else    exp_rsp.push_back('{32'd0, 1'b0, tag});
      end else begin
        exp_bus.push_back('{rcmd, ba, 32'd0, tag});
        if (ab) exp_rsp.push_back('{32'hFFFF_FFFF, 1'b1, tag});
        else begin
          mrg = (old & ~(mask << sh)) | ((wd & mask) << sh);
          exp_bus.push_back('{wcmd, ba, mrg, tag});
          exp_rsp.push_back('{32'd0, 1'b0, tag});
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_rsp.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                     input logic [31:0] wd, input string tag);
    issue(wr, sz, a, wd, tag);
    drain();
    chk({tag, " abort_flag"}, {31'd0, abort_flag}, {31'd0, tb_abort});
  endtask

  task automatic set_misc(input logic [7:0] v);
    @(negedge clk); misc_we = 1'b1; misc_wdata = v;
    @(negedge clk); misc_we = 1'b0;
    tb_cfg = v[1]; tb_hi = v[3:2];
    chk("R3 misc_q readback", {24'd0, misc_q}, {24'd0, v & 8'h3E});
  endtask

  task automatic clear_abort();
    @(negedge clk); abort_clr = 1'b1;
    @(negedge clk); abort_clr = 1'b0;
    tb_abort = 1'b0;
    chk("R9 abort_flag cleared", {31'd0, abort_flag}, 32'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=complete");
    summary();
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R12 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R12 bus_req", {31'd0, bus_req}, 32'd0);
    chk("R12 misc_q", {24'd0, misc_q}, 32'd0);
    chk("R12 rst_pin_oe", {31'd0, rst_pin_oe}, 32'd0);
    chk("R12 abort_flag", {31'd0, abort_flag}, 32'd0);

    // Memory window, lanes, merge
    run(1'b1, 2'd2, 32'h8000_0010, 32'hDEAD_BEEF, "R1 R6 full write");
    run(1'b0, 2'd2, 32'h8000_0010, 32'd0, "R1 full read");
    run(1'b0, 2'd0, 32'h8000_0011, 32'd0, "R5 byte off1");
    run(1'b0, 2'd0, 32'h8000_0013, 32'd0, "R5 byte off3");
    run(1'b0, 2'd1, 32'h8000_0012, 32'd0, "R5 half off2");
    run(1'b0, 2'd1, 32'h8000_0013, 32'd0, "R5 half off3");
    run(1'b1, 2'd0, 32'h8000_0011, 32'h0000_005A, "R6 byte write");
    run(1'b1, 2'd1, 32'h8000_0016, 32'hFFFF_1234, "R6 half write");
    run(1'b0, 2'd2, 32'h8000_0010, 32'd0, "R6 readback");
    run(1'b0, 2'd2, 32'h8000_0014, 32'd0, "R6 readback2");

    c0 = bus_cnt;
    run(1'b0, 2'd2, 32'h4000_0000, 32'd0, "R1 below window");
    run(1'b1, 2'd2, 32'hC000_0000, 32'h1, "R1 above window");
    chk("R1 no bus cycle outside window", bus_cnt, c0);

    set_misc(8'h0C);
    run(1'b0, 2'd2, 32'h8000_0010, 32'd0, "R2 upper bits 11");
    set_misc(8'h04);
    run(1'b0, 2'd2, 32'h8000_0018, 32'd0, "R2 upper bits 01");
    set_misc(8'h00);

    run(1'b0, 2'd2, 32'h8FF0_0000, 32'd0, "R7 memory read abort");
    clear_abort();
    run(1'b1, 2'd2, 32'h8FF0_0004, 32'h5, "R8 memory write abort");
    clear_abort();
    run(1'b1, 2'd0, 32'h8FF0_0009, 32'h7, "R7 merge read abort");
    clear_abort();

    // Configuration mode
    set_misc(8'h02);
    run(1'b0, 2'd2, 32'h0000_1108, 32'd0, "R3 cfg dev2 fn1 read");
    run(1'b0, 2'd1, 32'h0000_110A, 32'd0, "R3 R5 cfg half read");
    run(1'b1, 2'd0, 32'h0000_1109, 32'h0000_00C4, "R6 cfg byte write");
    run(1'b1, 2'd2, 32'h0000_100C, 32'h0BAD_F00D, "R6 cfg full write");
    run(1'b0, 2'd2, 32'h0000_1008, 32'd0, "R6 cfg readback");
    run(1'b0, 2'd2, 32'h0000_100C, 32'd0, "R6 cfg readback2");
    run(1'b0, 2'd2, 32'h0000_0008, 32'd0, "R7 cfg dev0 abort");
    clear_abort();
    c0 = bus_cnt;
    run(1'b0, 2'd2, 32'h0000_3800, 32'd0, "R4 dev7 limit");
    run(1'b1, 2'd2, 32'h0000_9800, 32'h1, "R4 dev19 range");
    chk("R4 no bus cycle", bus_cnt, c0);

    // Reset pin modes
    set_misc(8'h10);
    chk("R10 mode1 oe", {31'd0, rst_pin_oe}, 32'd1);
    chk("R10 mode1 level", {31'd0, rst_pin_o}, 32'd0);
    set_misc(8'h20);
    chk("R10 mode2 oe", {31'd0, rst_pin_oe}, 32'd1);
    chk("R10 mode2 level", {31'd0, rst_pin_o}, 32'd1);
    set_misc(8'h30);
    chk("R10 mode3 oe", {31'd0, rst_pin_oe}, 32'd0);
    set_misc(8'h00);
    chk("R10 mode0 oe", {31'd0, rst_pin_oe}, 32'd0);

    // Single outstanding transaction under response backpressure
    hold_rsp = 1'b1;
    repeat (2) @(negedge clk);
    issue(1'b0, 2'd2, 32'h8000_0004, 32'd0, "R11 held read");
    repeat (10) @(negedge clk);
    chk("R11 rsp held valid", {31'd0, rsp_valid}, 32'd1);
    chk("R11 req_ready low while pending", {31'd0, req_ready}, 32'd0);
    hold_rsp = 1'b0;
    drain();
    chk("R11 req_ready after consume", {31'd0, req_ready}, 32'd1);

    summary();
    $finish;
  end
endmodule